// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Interlock

This block is the hazard control for a five-stage in-order integer pipeline. Every cycle it looks at the source register numbers of the instruction in execute. It compares them with the destination numbers, write enables and memory-read flags in the pipeline registers behind that instruction. From this it picks, for each ALU operand, one source: the register file value, the EX/MEM result or the MEM/WB result. The selects drive the widened operand multiplexers in the datapath.

The register file returns a value that is written and read in the same cycle. So a consumer three instructions behind its producer needs no bypass, and the block has no write-back path.

A load delivers its data only after the memory stage. When the instruction in decode reads the destination of a load sitting in execute, the block raises a one-cycle stall:
- The PC and the IF/ID register hold, so the same instruction is fetched again.
- A bubble signal zeroes the control bundle that enters ID/EX.
- The zero controls travel down the pipeline like any other instruction's controls.
- On the next cycle the load is in MEM/WB and is reached by the normal bypass.

The block is purely combinational and sits between the pipeline registers and the hold and select inputs of the datapath.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When EX/MEM has its write enable set and its destination equals the execute-stage source (not r0), that operand's select is 2'b10.
- R2: When only MEM/WB has its write enable set and its destination matches a nonzero execute-stage source, the select is 2'b01.
- R3: When EX/MEM and MEM/WB both match the same source, the younger EX/MEM value wins and the select is 2'b10.
- R4: A source or destination of register 0 never forwards; the select stays 2'b00 (register file).
- R5: A pipeline register with its write enable low is never a forwarding source, even if its destination number matches.
- R6: Operand A (select fwd_a_o, from ex_rs_i) and operand B (select fwd_b_o, from ex_rt_i) are resolved independently. Both may forward from the same stage at once.
- R7: With no match in EX/MEM or MEM/WB the select is 2'b00. A reader three instructions behind its producer therefore reads the register file.
- R8: When ex_mrd_i is set and ex_rd_i is nonzero and equals id_rs_i or id_rt_i, pc_hold_o, ifid_hold_o and bubble_o are all 1 in that cycle.
- R9: With ex_mrd_i clear, or no decode-stage source matching a nonzero ex_rd_i, the three stall outputs are 0.
- R10: A load followed at once by a dependent instruction costs exactly one stall cycle. The cycle after the stall has no stall, and the dependent instruction then receives the load data through select 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs_i | input | REG_W | First source register of the instruction in decode |
| id_rt_i | input | REG_W | Second source register of the instruction in decode |
| ex_rs_i | input | REG_W | First source register of the instruction in execute |
| ex_rt_i | input | REG_W | Second source register of the instruction in execute |
| ex_rd_i | input | REG_W | Destination register of the instruction in execute |
| ex_mrd_i | input | 1 | Execute-stage instruction reads memory (load) |
| exm_rd_i | input | REG_W | Destination held in EX/MEM |
| exm_wen_i | input | 1 | Register write enable held in EX/MEM |
| mwb_rd_i | input | REG_W | Destination held in MEM/WB |
| mwb_wen_i | input | 1 | Register write enable held in MEM/WB |
| fwd_a_o | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_b_o | output | 2 | Operand B source, same encoding |
| pc_hold_o | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold_o | output | 1 | Keep the IF/ID register unchanged this cycle |
| bubble_o | output | 1 | Zero the control bundle entering ID/EX |

## Verification
Single-match patterns on one operand at a time show that each pipeline register is decoded to its own select code and that the two operands do not leak into each other. Double matches with mixed write enables separate the priority of the younger stage from the write-enable gate, and register-0 patterns show that the zero register is excluded. A replayed add-then-three-readers chain shows the bypass sequence 10, 01, 00 as the producer ages. A replayed load-then-use sequence, with the bubble fed into the modelled execute stage, shows that the stall lasts one cycle and that the load data is then picked up from MEM/WB.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  localparam int unsigned N_SRC = 2;
endpackage

// File: rtl/fwd_src_sel.sv
module fwd_src_sel #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] exm_rd_i,
  input  logic             exm_wen_i,
  input  logic [REG_W-1:0] mwb_rd_i,
  input  logic             mwb_wen_i,
  output fwd_pkg::fwd_sel_e sel_o
);
  import fwd_pkg::*;

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic src_live, hit_exm, hit_mwb;

  assign src_live = (src_i != ZERO_REG);
  assign hit_exm  = src_live && exm_wen_i && (exm_rd_i == src_i);
  assign hit_mwb  = src_live && mwb_wen_i && (mwb_rd_i == src_i);

  // younger result first
  always_comb begin
    if (hit_exm)      sel_o = FWD_EXM;
    else if (hit_mwb) sel_o = FWD_MWB;
    else              sel_o = FWD_RF;
  end
endmodule

// File: rtl/load_use_det.sv
module load_use_det #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0][REG_W-1:0] id_src_i,
  input  logic [REG_W-1:0]            ex_rd_i,
  input  logic                        ex_mrd_i,
  output logic                        stall_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [N_SRC-1:0] src_hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    assign src_hit[g] = (id_src_i[g] == ex_rd_i);
  end

  assign stall_o = ex_mrd_i && (ex_rd_i != ZERO_REG) && (|src_hit);
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic [REG_W-1:0] ex_rs_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_mrd_i,
  input  logic [REG_W-1:0] exm_rd_i,
  input  logic             exm_wen_i,
  input  logic [REG_W-1:0] mwb_rd_i,
  input  logic             mwb_wen_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             pc_hold_o,
  output logic             ifid_hold_o,
  output logic             bubble_o
);
  import fwd_pkg::*;

  logic [N_SRC-1:0][REG_W-1:0] ex_src, id_src;
  fwd_sel_e [N_SRC-1:0]        sel;
  logic                        stall;

  assign ex_src = {ex_rt_i, ex_rs_i};
  assign id_src = {id_rt_i, id_rs_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
    fwd_src_sel #(.REG_W(REG_W)) i_sel (
      .src_i    (ex_src[g]),
      .exm_rd_i (exm_rd_i),
      .exm_wen_i(exm_wen_i),
      .mwb_rd_i (mwb_rd_i),
      .mwb_wen_i(mwb_wen_i),
      .sel_o    (sel[g])
    );
  end

  load_use_det #(.REG_W(REG_W), .N_SRC(N_SRC)) i_lud (
    .id_src_i(id_src),
    .ex_rd_i (ex_rd_i),
    .ex_mrd_i(ex_mrd_i),
    .stall_o (stall)
  );

  assign fwd_a_o     = sel[0];
  assign fwd_b_o     = sel[1];
  assign pc_hold_o   = stall;
  assign ifid_hold_o = stall;
  assign bubble_o    = stall;
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] id_rs_i,
  input logic [REG_W-1:0] id_rt_i,
  input logic [REG_W-1:0] ex_rs_i,
  input logic [REG_W-1:0] ex_rt_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_mrd_i,
  input logic [REG_W-1:0] exm_rd_i,
  input logic             exm_wen_i,
  input logic [REG_W-1:0] mwb_rd_i,
  input logic             mwb_wen_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             pc_hold_o,
  input logic             ifid_hold_o,
  input logic             bubble_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    // R1
    exm_hit_chk: assert (!(exm_wen_i && ex_rs_i != ZERO_REG && exm_rd_i == ex_rs_i) || fwd_a_o == 2'b10)
      else $error("exm_hit_chk");
    // R3
    exm_prio_chk: assert (!(exm_wen_i && mwb_wen_i && ex_rt_i != ZERO_REG && exm_rd_i == ex_rt_i
                            && mwb_rd_i == ex_rt_i) || fwd_b_o == 2'b10)
      else $error("exm_prio_chk");
    // R4
    zero_src_chk: assert ((ex_rs_i != ZERO_REG || fwd_a_o == 2'b00) && (ex_rt_i != ZERO_REG || fwd_b_o == 2'b00))
      else $error("zero_src_chk");
    // R5
    wen_gate_chk: assert (exm_wen_i || mwb_wen_i || (fwd_a_o == 2'b00 && fwd_b_o == 2'b00))
      else $error("wen_gate_chk");
    // R8
    stall_agree_chk: assert (pc_hold_o == ifid_hold_o && ifid_hold_o == bubble_o)
      else $error("stall_agree_chk");
    // R8
    load_use_chk: assert (!(ex_mrd_i && ex_rd_i != ZERO_REG && (ex_rd_i == id_rs_i || ex_rd_i == id_rt_i)) || bubble_o)
      else $error("load_use_chk");
    // R9
    no_load_no_stall_chk: assert (ex_mrd_i || !bubble_o)
      else $error("no_load_no_stall_chk");
  end
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.REG_W(REG_W)) i_fwd_hazard_chk (
  .id_rs_i    (id_rs_i),
  .id_rt_i    (id_rt_i),
  .ex_rs_i    (ex_rs_i),
  .ex_rt_i    (ex_rt_i),
  .ex_rd_i    (ex_rd_i),
  .ex_mrd_i   (ex_mrd_i),
  .exm_rd_i   (exm_rd_i),
  .exm_wen_i  (exm_wen_i),
  .mwb_rd_i   (mwb_rd_i),
  .mwb_wen_i  (mwb_wen_i),
  .fwd_a_o    (fwd_a_o),
  .fwd_b_o    (fwd_b_o),
  .pc_hold_o  (pc_hold_o),
  .ifid_hold_o(ifid_hold_o),
  .bubble_o   (bubble_o)
);

// File: tb/test_fwd_hazard_unit.sv
module test_fwd_hazard_unit;
  localparam int unsigned REG_W = 5;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       stall;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, exm_rd, mwb_rd;
  logic ex_mrd, exm_wen, mwb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, bubble;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  fwd_hazard_unit #(.REG_W(REG_W)) i_fwd_hazard_unit (
    .id_rs_i(id_rs), .id_rt_i(id_rt), .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
    .ex_rd_i(ex_rd), .ex_mrd_i(ex_mrd), .exm_rd_i(exm_rd), .exm_wen_i(exm_wen),
    .mwb_rd_i(mwb_rd), .mwb_wen_i(mwb_wen), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .bubble_o(bubble)
  );

  // driver: one stage snapshot per cycle, expectation queued
  task automatic vec(input int irs, input int irt, input int ers, input int ert,
                     input int erd, input bit emrd, input int xrd, input bit xwen,
                     input int wrd, input bit wwen, input logic [1:0] ea,
                     input logic [1:0] eb, input bit est, input string tag);
    exp_t e;
    @(posedge clk);
    id_rs = REG_W'(irs); id_rt = REG_W'(irt); ex_rs = REG_W'(ers); ex_rt = REG_W'(ert);
    ex_rd = REG_W'(erd); ex_mrd = emrd; exm_rd = REG_W'(xrd); exm_wen = xwen;
    mwb_rd = REG_W'(wrd); mwb_wen = wwen;
    e.a = ea; e.b = eb; e.stall = est; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (fwd_a !== e.a || fwd_b !== e.b || pc_hold !== e.stall
            || ifid_hold !== e.stall || bubble !== e.stall) begin
          n_fail++;
          $display("FAIL %s: got a=%b b=%b hold=%b/%b bubble=%b, exp a=%b b=%b stall=%b",
                   e.tag, fwd_a, fwd_b, pc_hold, ifid_hold, bubble, e.a, e.b, e.stall);
        end
      end
    end
  end

  initial begin
    id_rs = '0; id_rt = '0; ex_rs = '0; ex_rt = '0; ex_rd = '0; ex_mrd = 1'b0;
    exm_rd = '0; exm_wen = 1'b0; mwb_rd = '0; mwb_wen = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    vec(0,0, 0,0, 0,0, 0,0, 0,0, 2'b00,2'b00,0, "R4 idle all zero");
    vec(0,0, 3,5, 0,0, 3,1, 0,0, 2'b10,2'b00,0, "R1 exm to A");
    vec(0,0, 8,7, 0,0, 0,0, 7,1, 2'b00,2'b01,0, "R2 mwb to B");
    vec(0,0, 4,0, 0,0, 4,1, 4,1, 2'b10,2'b00,0, "R3 both match A");
    vec(0,0, 0,4, 0,0, 4,1, 4,1, 2'b00,2'b10,0, "R3 both match B");
    vec(0,0, 0,0, 0,0, 0,1, 0,1, 2'b00,2'b00,0, "R4 r0 never forwards");
    vec(0,0, 6,6, 0,0, 6,0, 6,0, 2'b00,2'b00,0, "R5 wen low both");
    vec(0,0, 6,0, 0,0, 6,0, 6,1, 2'b01,2'b00,0, "R5 exm wen low falls to mwb");
    vec(0,0, 2,9, 0,0, 9,1, 2,1, 2'b01,2'b10,0, "R6 independent operands");
    vec(0,0, 9,9, 0,0, 9,1, 0,0, 2'b10,2'b10,0, "R6 same reg both operands");
    // add r1; sub r4,r1,r3; and r6,r1,r7; or r8,r1,r9
    vec(1,9, 1,3, 4,0, 1,1, 0,0, 2'b10,2'b00,0, "R1 chain first reader");
    vec(0,0, 1,7, 6,0, 4,1, 1,1, 2'b01,2'b00,0, "R2 chain second reader");
    vec(0,0, 1,9, 8,0, 6,1, 4,1, 2'b00,2'b00,0, "R7 chain third reader");
    vec(0,0, 0,0, 0,0, 0,0, 0,0, 2'b00,2'b00,0, "R7 drain");
    vec(5,0, 0,0, 5,1, 0,0, 0,0, 2'b00,2'b00,1, "R8 load-use on rs");
    vec(0,5, 0,0, 5,1, 0,0, 0,0, 2'b00,2'b00,1, "R8 load-use on rt");
    vec(5,5, 0,0, 5,0, 0,0, 0,0, 2'b00,2'b00,0, "R9 match without load");
    vec(0,0, 0,0, 0,1, 0,0, 0,0, 2'b00,2'b00,0, "R9 load to r0");
    vec(3,4, 0,0, 5,1, 0,0, 0,0, 2'b00,2'b00,0, "R9 load no match");
    // lw r1; sub r4,r1,r6: stall, bubble in EX, then bypass from MEM/WB
    vec(1,6, 0,0, 1,1, 0,0, 0,0, 2'b00,2'b00,1, "R10 stall cycle");
    vec(1,6, 0,0, 0,0, 1,0, 0,0, 2'b00,2'b00,0, "R10 single stall");
    vec(0,0, 1,6, 4,0, 0,0, 1,1, 2'b01,2'b00,0, "R10 load data via mwb");

    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d expectations left unchecked, expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog expired, got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule